// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt request lines and forwards each enabled, active request to one of four parent interrupt outputs and to any subset of four processor cores. Software sets it up through a small register bus. It can write a byte or a word and it reads a word. For each source, software picks the trigger style (level or edge) and the active sense (high/rising or low/falling). Software also turns each source on or off through separate set and clear words.

Each source owns one routing byte. The upper nibble of that byte picks the parent line. The lower nibble is a mask of the cores that see the source. Software can read the enabled pending word, the raw active word before enabling, and one pending word for each core. An edge-triggered source holds its event in a sticky bit until software writes a one to that source's position at the pending-status offset.

Top module: `route_irq_ctrl`

## Requirements
- R1: A byte write (data on bits 7:0) to offset n, for n from 0x00 to 0x1F, sets the routing byte of source n. An aligned word write or word read at offsets 0x00 to 0x1C covers sources 4m to 4m+3, and source 4m+j sits in bits 8j+7:8j.
- R2: Within a routing byte, bit 4+k routes the source to parent output k, and bit c (for c from 0 to 3) routes it to core c.
- R3: A word write to 0x28 sets the enable bit of every source whose data bit is 1. A word write to 0x2C clears the enable bit of every source whose data bit is 1. Zero data bits change nothing. A read of 0x24 returns the enable word.
- R4: Offset 0x30 holds the polarity word and offset 0x34 holds the edge word. Both take word writes and return their value on a read.
- R5: A level source (edge bit 0) is active when its input equals its polarity bit: high if polarity is 1, low if polarity is 0.
- R6: An edge source (edge bit 1) latches on a rising input when polarity is 1, and on a falling input when polarity is 0. A word write to 0x40 clears the latch of every source whose data bit is 1. If a new edge arrives in the same cycle as the clear, the latch stays set.
- R7: A read of 0x40 returns the active and enabled sources. A read of 0x44 returns the active sources regardless of enable.
- R8: Parent output k is high exactly when some enabled, active source has routing bit 4+k set.
- R9: Core output c is high exactly when some enabled, active source has routing bit c set. A read of 0x60+4c returns that core's pending word.
- R10: After reset, all enable, polarity, edge and routing state is 0, the read data is 0, and no output is asserted.
- R11: Reads of unmapped, write-only or unaligned offsets return 0. Writes to them are ignored, and so are word writes to 0x24 and byte writes above 0x1F.
- R12: Read data is registered. It appears in the cycle after the read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_byte_i | input | 1 | 1 = byte write, 0 = word access |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_i | input | 32 | Interrupt source lines (already synchronous) |
| parent_irq_o | output | 4 | Parent interrupt outputs |
| core_irq_o | output | 4 | Per-core interrupt outputs |

## Verification
The bench checks that an edge latch survives after its input drops. It also drives an edge into the same cycle as a status clear. A design that lets the clear win would lose that interrupt. A design that inverts the polarity rule would light the outputs with the lines idle. Routing bytes are written both as single bytes and as packed words. A lane swap then shows up as the wrong parent or core. Writes to the read-only enable offset, byte writes into the control area and reads of unaligned or write-only offsets are all checked. A decoder that is too loose would corrupt state or leak data there.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
  localparam int unsigned OFS_EN_RD  = 'h24;
  localparam int unsigned OFS_EN_SET = 'h28;
  localparam int unsigned OFS_EN_CLR = 'h2C;
  localparam int unsigned OFS_POL    = 'h30;
  localparam int unsigned OFS_EDGE   = 'h34;
  localparam int unsigned OFS_STAT   = 'h40;
  localparam int unsigned OFS_RAW    = 'h44;
  localparam int unsigned OFS_CORE   = 'h60;
  localparam int unsigned PAR_W      = 4;
  localparam int unsigned CORE_W     = 4;

  typedef struct packed {
    logic [PAR_W-1:0]  par;
    logic [CORE_W-1:0] core;
  } route_t;
endpackage

// File: rtl/rlic_regs.sv
module rlic_regs
  import rlic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned AW     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_valid_i,
  input  logic                           bus_write_i,
  input  logic                           bus_byte_i,
  input  logic [AW-1:0]                  bus_addr_i,
  input  logic [N_SRC-1:0]               bus_wdata_i,
  input  logic [N_SRC-1:0]               raw_i,
  input  logic [N_SRC-1:0]               pend_i,
  input  logic [N_CORE-1:0][N_SRC-1:0]   core_pend_i,
  output route_t [N_SRC-1:0]             route_o,
  output logic [N_SRC-1:0]               en_o,
  output logic [N_SRC-1:0]               pol_o,
  output logic [N_SRC-1:0]               edge_o,
  output logic [N_SRC-1:0]               clr_o,
  output logic [N_SRC-1:0]               rdata_o
);
  localparam int unsigned LANES = N_SRC / 8;

  logic wr_word, wr_byte, rd_req, aligned, in_route;
  route_t [N_SRC-1:0] route_q;
  logic [N_SRC-1:0] en_q, pol_q, edge_q, rdata_q, rd_val;

  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign in_route = (bus_addr_i < AW'(N_SRC));
  assign wr_word  = bus_valid_i & bus_write_i & ~bus_byte_i & aligned;
  assign wr_byte  = bus_valid_i & bus_write_i & bus_byte_i;
  assign rd_req   = bus_valid_i & ~bus_write_i;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned ofs);
    return a == AW'(ofs);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (wr_byte && bus_addr_i == AW'(i))
          route_q[i] <= bus_wdata_i[7:0];
        else if (wr_word && in_route && bus_addr_i[AW-1:2] == (AW-2)'(i / 4))
          route_q[i] <= bus_wdata_i[8*(i%4) +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else if (wr_word) begin
      if (hit(bus_addr_i, OFS_EN_SET)) en_q   <= en_q | bus_wdata_i;
      if (hit(bus_addr_i, OFS_EN_CLR)) en_q   <= en_q & ~bus_wdata_i;
      if (hit(bus_addr_i, OFS_POL))    pol_q  <= bus_wdata_i;
      if (hit(bus_addr_i, OFS_EDGE))   edge_q <= bus_wdata_i;
    end
  end

  assign clr_o = (wr_word && hit(bus_addr_i, OFS_STAT)) ? bus_wdata_i : '0;

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (in_route) begin
        for (int i = 0; i < N_SRC; i++)
          if (bus_addr_i[AW-1:2] == (AW-2)'(i / 4))
            rd_val[8*(i%4) +: 8] = route_q[i];
      end else if (hit(bus_addr_i, OFS_EN_RD)) rd_val = en_q;
      else if (hit(bus_addr_i, OFS_POL))       rd_val = pol_q;
      else if (hit(bus_addr_i, OFS_EDGE))      rd_val = edge_q;
      else if (hit(bus_addr_i, OFS_STAT))      rd_val = pend_i;
      else if (hit(bus_addr_i, OFS_RAW))       rd_val = raw_i;
      else begin
        for (int c = 0; c < N_CORE; c++)
          if (hit(bus_addr_i, OFS_CORE + 4 * c)) rd_val = core_pend_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_val;
  end

  assign route_o = route_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign edge_o  = edge_q;
  assign rdata_o = rdata_q;

  if (LANES != 4) begin : g_bad_width
    initial $error("rlic_regs: N_SRC must be 32");
  end
endmodule

// File: rtl/rlic_trig.sv
module rlic_trig #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] raw_o
);
  logic [N_SRC-1:0] prev_q, latch_q, rise, fall, evt, lvl;

  assign rise = irq_i & ~prev_q;
  assign fall = ~irq_i & prev_q;
  assign evt  = edge_i & ((pol_i & rise) | (~pol_i & fall));
  assign lvl  = ~(irq_i ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= irq_i;
      // new edge beats a same-cycle clear
      latch_q <= (latch_q & edge_i & ~clr_i) | evt;
    end
  end

  assign raw_o = (edge_i & latch_q) | (~edge_i & lvl);
endmodule

// File: rtl/rlic_route.sv
module rlic_route
  import rlic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PAR  = 4,
  parameter int unsigned N_CORE = 4
) (
  input  logic [N_SRC-1:0]             pend_i,
  input  route_t [N_SRC-1:0]           route_i,
  output logic [N_PAR-1:0]             par_o,
  output logic [N_CORE-1:0]            core_o,
  output logic [N_CORE-1:0][N_SRC-1:0] core_pend_o
);
  for (genvar k = 0; k < N_PAR; k++) begin : g_par
    logic [N_SRC-1:0] sel;
    always_comb
      for (int i = 0; i < N_SRC; i++) sel[i] = route_i[i].par[k];
    assign par_o[k] = |(sel & pend_i);
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    logic [N_SRC-1:0] sel;
    always_comb
      for (int i = 0; i < N_SRC; i++) sel[i] = route_i[i].core[c];
    assign core_pend_o[c] = sel & pend_i;
    assign core_o[c]      = |core_pend_o[c];
  end
endmodule

// File: rtl/route_irq_ctrl.sv
module route_irq_ctrl
  import rlic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PAR  = 4,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              bus_byte_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  input  logic [N_SRC-1:0]  irq_i,
  output logic [N_PAR-1:0]  parent_irq_o,
  output logic [N_CORE-1:0] core_irq_o
);
  route_t [N_SRC-1:0]           route;
  logic [N_SRC-1:0]             en, pol_sel, edge_sel, clr_mask, raw, pend;
  logic [N_CORE-1:0][N_SRC-1:0] core_pend;

  rlic_regs #(.N_SRC(N_SRC), .N_CORE(N_CORE), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_byte_i  (bus_byte_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .raw_i       (raw),
    .pend_i      (pend),
    .core_pend_i (core_pend),
    .route_o     (route),
    .en_o        (en),
    .pol_o       (pol_sel),
    .edge_o      (edge_sel),
    .clr_o       (clr_mask),
    .rdata_o     (bus_rdata_o)
  );

  rlic_trig #(.N_SRC(N_SRC)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .pol_i  (pol_sel),
    .edge_i (edge_sel),
    .clr_i  (clr_mask),
    .raw_o  (raw)
  );

  assign pend = raw & en;

  rlic_route #(.N_SRC(N_SRC), .N_PAR(N_PAR), .N_CORE(N_CORE)) u_route (
    .pend_i      (pend),
    .route_i     (route),
    .par_o       (parent_irq_o),
    .core_o      (core_irq_o),
    .core_pend_o (core_pend)
  );
endmodule

// File: rtl/rlic_chk.sv
module rlic_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PAR  = 4,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned AW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic              bus_byte_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [N_SRC-1:0]  bus_wdata_i,
  input logic [N_SRC-1:0]  bus_rdata_o,
  input logic [N_SRC-1:0]  irq_i,
  input logic [N_SRC-1:0]  en,
  input logic [N_SRC-1:0]  pol_sel,
  input logic [N_SRC-1:0]  edge_sel,
  input logic [N_SRC-1:0]  clr_mask,
  input logic [N_SRC-1:0]  raw,
  input logic [N_SRC-1:0]  pend,
  input logic [N_PAR-1:0]  parent_irq_o,
  input logic [N_CORE-1:0] core_irq_o
);
  logic wword, rd, readable;

  assign wword = bus_valid_i & bus_write_i & ~bus_byte_i;
  assign rd    = bus_valid_i & ~bus_write_i;

  always_comb begin
    readable = 1'b0;
    if (bus_addr_i[1:0] == 2'b00) begin
      if (bus_addr_i < AW'(N_SRC)) readable = 1'b1;
      if (bus_addr_i == AW'('h24) || bus_addr_i == AW'('h30) || bus_addr_i == AW'('h34) ||
          bus_addr_i == AW'('h40) || bus_addr_i == AW'('h44)) readable = 1'b1;
      for (int c = 0; c < N_CORE; c++)
        if (bus_addr_i == AW'('h60 + 4 * c)) readable = 1'b1;
    end
  end

  p_en_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wword && bus_addr_i == AW'('h28)) |=> ((en & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wword && bus_addr_i == AW'('h2C)) |=> ((en & $past(bus_wdata_i)) == '0));

  p_en_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wword && (bus_addr_i == AW'('h28) || bus_addr_i == AW'('h2C))) |=> $stable(en));

  p_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw ^ ~(irq_i ^ pol_sel)) & ~edge_sel) == '0);

  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(raw & edge_sel & ~clr_mask) & edge_sel & ~raw) == '0);

  p_parent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|parent_irq_o) |-> (|pend));

  p_core_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|core_irq_o) |-> (|pend));

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !readable) |=> (bus_rdata_o == '0));

  p_rd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(bus_rdata_o));
endmodule

bind route_irq_ctrl rlic_chk #(.N_SRC(N_SRC), .N_PAR(N_PAR), .N_CORE(N_CORE), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_byte_i   (bus_byte_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_i        (irq_i),
  .en           (en),
  .pol_sel      (pol_sel),
  .edge_sel     (edge_sel),
  .clr_mask     (clr_mask),
  .raw          (raw),
  .pend         (pend),
  .parent_irq_o (parent_irq_o),
  .core_irq_o   (core_irq_o)
);

// File: tb/route_irq_ctrl_tb_top.sv
module route_irq_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0, bsel = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, irq = '0;
  logic [31:0] rdata;
  logic [3:0] par, core;
  int n_cmp = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  route_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_byte_i(bsel), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_i(irq), .parent_irq_o(par), .core_irq_o(core)
  );

  // behavioural reference
  logic [7:0]  m_route [N];
  logic [31:0] m_en, m_pol, m_edge, m_latch, m_prev, m_rdata;

  function automatic logic [31:0] m_raw();
    logic [31:0] r;
    for (int i = 0; i < N; i++)
      r[i] = m_edge[i] ? m_latch[i] : (m_pol[i] ? irq[i] : !irq[i]);
    return r;
  endfunction

  function automatic logic [31:0] m_pend();
    return m_raw() & m_en;
  endfunction

  function automatic logic [31:0] m_view(input int bitpos);
    logic [31:0] v = '0;
    logic [31:0] p = m_pend();
    for (int i = 0; i < N; i++) v[i] = p[i] && m_route[i][bitpos];
    return v;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a < 8'd32) return {m_route[a+3], m_route[a+2], m_route[a+1], m_route[a]};
    case (a)
      8'h24: return m_en;
      8'h30: return m_pol;
      8'h34: return m_edge;
      8'h40: return m_pend();
      8'h44: return m_raw();
      8'h60: return m_view(0);
      8'h64: return m_view(1);
      8'h68: return m_view(2);
      8'h6C: return m_view(3);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_route[i] = '0;
      m_en = '0; m_pol = '0; m_edge = '0; m_latch = '0; m_prev = '0; m_rdata = '0;
    end else begin
      logic [31:0] clr;
      if (valid && !write) m_rdata = m_read(addr);
      clr = (valid && write && !bsel && addr == 8'h40) ? wdata : '0;
      for (int i = 0; i < N; i++) begin
        logic ev;
        ev = m_edge[i] && (m_pol[i] ? (irq[i] && !m_prev[i]) : (!irq[i] && m_prev[i]));
        m_latch[i] = ev || (m_edge[i] && m_latch[i] && !clr[i]);
      end
      m_prev = irq;
      if (valid && write) begin
        if (bsel) begin
          if (addr < 8'd32) m_route[addr] = wdata[7:0];
        end else if (addr[1:0] == 2'b00) begin
          if (addr < 8'd32) begin
            for (int j = 0; j < 4; j++) m_route[addr+j] = wdata[8*j +: 8];
          end else begin
            case (addr)
              8'h28: m_en = m_en | wdata;
              8'h2C: m_en = m_en & ~wdata;
              8'h30: m_pol = wdata;
              8'h34: m_edge = wdata;
              default: ;
            endcase
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [3:0] ep, ec;
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        ep[k] = |m_view(4 + k);
        ec[k] = |m_view(k);
      end
      chk(par == ep, "R8 parent outputs", 32'(par), 32'(ep));
      chk(core == ec, "R9 core outputs", 32'(core), 32'(ec));
      chk(rdata == m_rdata, "R12 read data", rdata, m_rdata);
    end
  endtask

  task automatic wr_w(input logic [7:0] a, input logic [31:0] d);
    valid = 1; write = 1; bsel = 0; addr = a; wdata = d;
    tick();
    valid = 0; write = 0;
  endtask

  task automatic wr_b(input logic [7:0] a, input logic [7:0] d);
    valid = 1; write = 1; bsel = 1; addr = a; wdata = {24'h0, d};
    tick();
    valid = 0; write = 0; bsel = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    valid = 1; write = 0; bsel = 0; addr = a;
    tick();
    valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(par == 0 && core == 0, "R10 outputs in reset", 32'({par, core}), 0);
    rst_n = 1;
    tick();
    chk(rdata == 0, "R10 read data after reset", rdata, 0);
    rd(8'h30); chk(rdata == 0, "R10 polarity reset", rdata, 0);
    rd(8'h34); chk(rdata == 0, "R10 edge reset", rdata, 0);
    rd(8'h1C); chk(rdata == 0, "R10 route reset", rdata, 0);
    rd(8'h24); chk(rdata == 0, "R10 enable reset", rdata, 0);

    // routing bytes
    wr_w(8'h08, 32'h11223344);
    wr_b(8'h05, 8'h23);
    rd(8'h08); chk(rdata == 32'h11223344, "R1 word route", rdata, 32'h11223344);
    rd(8'h04); chk(rdata == 32'h00002300, "R1 byte route", rdata, 32'h00002300);

    // enable, polarity, routing
    irq = '1;
    wr_w(8'h30, 32'hFFFFFFFF);
    rd(8'h30); chk(rdata == 32'hFFFFFFFF, "R4 polarity readback", rdata, 32'hFFFFFFFF);
    wr_w(8'h28, 32'h00000120);
    rd(8'h24); chk(rdata == 32'h120, "R3 enable set", rdata, 32'h120);
    rd(8'h40); chk(rdata == 32'h120, "R7 pending status", rdata, 32'h120);
    chk(par == 4'b0110, "R2 parent select", 32'(par), 32'h6);
    chk(core == 4'b0111, "R2 core mask", 32'(core), 32'h7);
    rd(8'h64); chk(rdata == 32'h20, "R9 core1 view", rdata, 32'h20);
    wr_w(8'h2C, 32'h00000020);
    rd(8'h24); chk(rdata == 32'h100, "R3 enable clear", rdata, 32'h100);
    chk(par == 4'b0100, "R8 parent after clear", 32'(par), 32'h4);

    // level sense
    wr_w(8'h30, 32'h0);
    rd(8'h40); chk(rdata == 0, "R5 active-low idle", rdata, 0);
    irq = 32'hFFFFFEFF;
    rd(8'h40); chk(rdata == 32'h100, "R5 active-low asserted", rdata, 32'h100);

    // edge sense
    irq = '0;
    wr_w(8'h30, 32'h100);
    wr_w(8'h34, 32'h100);
    rd(8'h34); chk(rdata == 32'h100, "R4 edge readback", rdata, 32'h100);
    rd(8'h44); chk(rdata == 32'hFFFFFEFF, "R7 raw status", rdata, 32'hFFFFFEFF);
    irq[8] = 1; tick();
    irq[8] = 0; tick();
    rd(8'h40); chk(rdata == 32'h100, "R6 rising latched", rdata, 32'h100);
    wr_w(8'h40, 32'h100);
    rd(8'h40); chk(rdata == 0, "R6 latch cleared", rdata, 0);
    irq[8] = 1;
    wr_w(8'h40, 32'h100);
    rd(8'h40); chk(rdata == 32'h100, "R6 edge beats clear", rdata, 32'h100);
    wr_w(8'h30, 32'h0);
    wr_w(8'h40, 32'h100);
    rd(8'h40); chk(rdata == 0, "R6 cleared before fall", rdata, 0);
    irq[8] = 0; tick();
    rd(8'h40); chk(rdata == 32'h100, "R6 falling latched", rdata, 32'h100);
    wr_w(8'h30, 32'h100);

    // unmapped and ignored accesses
    rd(8'h38); chk(rdata == 0, "R11 unmapped read", rdata, 0);
    rd(8'h28); chk(rdata == 0, "R11 write-only read", rdata, 0);
    rd(8'h31); chk(rdata == 0, "R11 unaligned read", rdata, 0);
    wr_w(8'h38, 32'hFFFFFFFF);
    wr_b(8'h30, 8'hFF);
    wr_w(8'h24, 32'h0);
    wr_w(8'h32, 32'hFFFFFFFF);
    rd(8'h30); chk(rdata == 32'h100, "R11 polarity untouched", rdata, 32'h100);
    rd(8'h24); chk(rdata == 32'h100, "R11 enable untouched", rdata, 32'h100);

    // read data hold
    wr_w(8'h30, 32'h5);
    tick();
    chk(rdata == 32'h100, "R12 hold after write", rdata, 32'h100);
    rd(8'h30); chk(rdata == 32'h5, "R12 new read", rdata, 32'h5);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int s;
      irq = irq ^ ($urandom & $urandom & $urandom);
      s = $urandom_range(0, 15);
      valid = ($urandom_range(0, 3) != 0);
      write = $urandom_range(0, 1);
      bsel  = write && ($urandom_range(0, 3) == 0);
      wdata = $urandom;
      case (s)
        0, 1:  addr = 8'($urandom_range(0, 7) * 4);
        2:     addr = 8'($urandom_range(0, 31));
        3, 4:  addr = 8'h28;
        5:     addr = 8'h2C;
        6:     addr = 8'h30;
        7:     addr = 8'h34;
        8, 9:  addr = 8'h40;
        10:    addr = 8'h44;
        11:    addr = 8'h24;
        12, 13: addr = 8'(8'h60 + $urandom_range(0, 3) * 4);
        default: addr = 8'($urandom_range(0, 255));
      endcase
      tick();
    end
    valid = 0;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule